// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral placed behind a plain single-cycle register bus. Software drives output levels through a write-1-to-set register, a write-1-to-clear register or a whole-word data write. It picks line directions through an output-direction register or an input-direction register. The two direction registers are two views of one stored direction word, so no line can be both an input and an output. Input pins pass through a two-flop synchroniser before they can be read.

The register width is a parameter, and the line count equals that width. Two elaboration-time options change how register bits map to the bus. The first mirrors the line order. The second reverses the byte lanes. Both options apply in the same way to every register, for reads and for writes. The block drives a value and an enable for each line. An external pad ring turns these into the actual pins.

Top module: `mmio_gpio`

## Requirements
- R1: During and after synchronous reset, every output value and every output enable is 0. The output-direction register reads 0 and the input-direction register reads all ones.
- R2: The registers sit at these word offsets: 0 data, 1 set, 2 clear, 3 output-direction, 4 input-direction. Reading the data register returns, for each line, the output latch if the line is an output. If the line is an input, it returns the input pin as sampled through two flops.
- R3: Writing offset 1 sets to 1 the latch bit of every line whose written bit is 1. Lines whose written bit is 0 keep their value.
- R4: Writing offset 2 clears to 0 the latch bit of every line whose written bit is 1. Lines whose written bit is 0 keep their value.
- R5: Writing offset 0 loads the whole output latch with the written value.
- R6: Reading offset 1 returns the output latch. Reading offset 2 returns zero.
- R7: Writing offset 3 stores the direction word, with 1 meaning output. Each line's output enable equals its direction bit, and reading offset 3 returns the word.
- R8: Writing offset 4 stores the complement of the written value as the direction word. Reading offset 4 always returns the complement of offset 3.
- R9: Reads at offsets 5 to 7 return zero. Writes there change no output, no enable and no register.
- R10: Read data appears on the port in the cycle after the read strobe and holds until the next read strobe. The output latch and the enables change in the cycle after the write strobe.
- R11: With the mirror option set, line n appears at register bit W-1-n in every register. Otherwise line n appears at bit n.
- R12: With the byte-swap option set, bus byte k carries register byte W/8-1-k, in both directions. Elaboration rejects this option at 64-bit width, and it rejects widths other than 8, 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register word offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | W | Write data in bus order |
| rdata | output | W | Registered read data in bus order |
| gpio_in | input | W | Asynchronous input pins, line order |
| gpio_out | output | W | Output latch, line order |
| gpio_oe | output | W | Output enables, 1 = drive, line order |

## Verification
A write strobe seen at one rising edge updates the output latch and the enables at that same edge. The bench therefore drives the strobe at a falling edge and compares the outputs at the next falling edge. Read data is also due one edge after the strobe. A pin change reaches read data only at the third edge after the change: the first two reads still return the old level, and a directed test checks exactly that sequence. Random pin changes are followed by three idle cycles before any data read, so the model can take the settled pin value. Each transaction is checked against two instances at the same time, one plain and one with both mapping options set.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;

  typedef enum logic [2:0] {
    SEL_DATA   = 3'd0,
    SEL_SET    = 3'd1,
    SEL_CLR    = 3'd2,
    SEL_DIROUT = 3'd3,
    SEL_DIRIN  = 3'd4,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  localparam int NUM_REGS = 5;

  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    if (off < 32'(NUM_REGS)) return reg_sel_e'(off[2:0]);
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/gpio_lane_map.sv
// Bit permutation between line order and bus order. Mirror and byte swap
// commute and are each their own inverse, so one instance serves each path.
module gpio_lane_map #(
  parameter int W         = 32,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam int NBYTES = W / 8;

  logic [W-1:0] mirrored;

  generate
    if (MIRROR) begin : g_mirror
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign mirrored[i] = a[W-1-i];
      end
    end else begin : g_straight
      assign mirrored = a;
    end

    if (BYTE_SWAP) begin : g_swap
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign y[8*k +: 8] = mirrored[8*(NBYTES-1-k) +: 8];
      end
    end else begin : g_keep
      assign y = mirrored;
    end
  endgenerate
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      pin_sync <= '0;
    end else begin
      stage1   <= pin_async;
      pin_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_core.sv
module gpio_core
  import mmio_gpio_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [W-1:0]      wline,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      rd_q
);
  reg_sel_e     sel;
  logic [W-1:0] rd_val;

  assign sel = decode_offset(32'(addr));

  always_comb begin
    unique case (sel)
      SEL_DATA:   rd_val = (dir_q & out_q) | (~dir_q & pin_sync);
      SEL_SET:    rd_val = out_q;
      SEL_DIROUT: rd_val = dir_q;
      SEL_DIRIN:  rd_val = ~dir_q;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr_en) begin
        unique case (sel)
          SEL_DATA:   out_q <= wline;
          SEL_SET:    out_q <= out_q | wline;
          SEL_CLR:    out_q <= out_q & ~wline;
          SEL_DIROUT: dir_q <= wline;
          SEL_DIRIN:  dir_q <= ~wline;
          default:    ;
        endcase
      end
      if (rd_en) rd_q <= rd_val;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (out_q == '0 && dir_q == '0 && rd_q == '0));

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_SET) |=> ((out_q & $past(wline)) == $past(wline)));

  p_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CLR) |=> ((out_q & $past(wline)) == '0));

  p_data_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DATA) |=> (out_q == $past(wline)));

  p_dirout_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DIROUT) |=> (dir_q == $past(wline)));

  p_dirin_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DIRIN) |=> (dir_q == ~$past(wline)));

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || sel == SEL_NONE) |=> ($stable(out_q) && $stable(dir_q)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio #(
  parameter int W         = 32,
  parameter int ADDR_W    = 3,
  parameter bit MIRROR    = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      gpio_in,
  output logic [W-1:0]      gpio_out,
  output logic [W-1:0]      gpio_oe
);
  generate
    if (!(W == 8 || W == 16 || W == 32 || W == 64)) begin : g_bad_width
      $error("mmio_gpio: W must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && W == 64) begin : g_bad_swap
      $error("mmio_gpio: byte swap is not allowed at 64-bit width");
    end
  endgenerate

  logic [W-1:0] wline;
  logic [W-1:0] pin_sync;
  logic [W-1:0] rd_line;

  gpio_lane_map #(.W(W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
    .a (wdata),
    .y (wline)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (gpio_in),
    .pin_sync  (pin_sync)
  );

  gpio_core #(.W(W), .ADDR_W(ADDR_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wline    (wline),
    .pin_sync (pin_sync),
    .out_q    (gpio_out),
    .dir_q    (gpio_oe),
    .rd_q     (rd_line)
  );

  gpio_lane_map #(.W(W), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
    .a (rd_line),
    .y (rdata)
  );
endmodule

// File: tb/mmio_gpio_bench.sv
`timescale 1ns/1ps
module mmio_gpio_bench;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] gpio_in = '0;
  logic [W-1:0] rdata0, rdata1, out0, out1, oe0, oe1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] out_m [2];
  logic [W-1:0] dir_m [2];
  logic [W-1:0] pins_m = '0;

  always #2 clk = ~clk;

  mmio_gpio #(.W(W), .ADDR_W(3), .MIRROR(1'b0), .BYTE_SWAP(1'b0)) u_mmio_gpio (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata0), .gpio_in(gpio_in),
    .gpio_out(out0), .gpio_oe(oe0)
  );

  mmio_gpio #(.W(W), .ADDR_W(3), .MIRROR(1'b1), .BYTE_SWAP(1'b1)) u_mmio_gpio_alt (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata1), .gpio_in(gpio_in),
    .gpio_out(out1), .gpio_oe(oe1)
  );

  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] byte_rev(input logic [W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // R11/R12 mapping of the alternate instance (its own inverse)
  function automatic logic [W-1:0] xmap(input int k, input logic [W-1:0] v);
    return (k == 1) ? byte_rev(bit_rev(v)) : v;
  endfunction

  function automatic logic [W-1:0] exp_read(input int k, input int off);
    logic [W-1:0] v;
    case (off)
      0: v = (dir_m[k] & out_m[k]) | (~dir_m[k] & pins_m);
      1: v = out_m[k];
      3: v = dir_m[k];
      4: v = ~dir_m[k];
      default: v = '0;
    endcase
    return xmap(k, v);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string wr_tag(input int off);
    case (off)
      0: return "R5"; 1: return "R3"; 2: return "R4";
      3: return "R7"; 4: return "R8"; default: return "R9";
    endcase
  endfunction

  function automatic string rd_tag(input int off);
    case (off)
      0: return "R2"; 1: return "R6"; 2: return "R6";
      3: return "R7"; 4: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic do_write(input int off, input logic [W-1:0] d);
    addr = 3'(off); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      logic [W-1:0] l;
      l = xmap(k, d);
      case (off)
        0: out_m[k] = l;
        1: out_m[k] = out_m[k] | l;
        2: out_m[k] = out_m[k] & ~l;
        3: dir_m[k] = l;
        4: dir_m[k] = ~l;
        default: ;
      endcase
    end
    chk({wr_tag(off), " R10 out main"}, out0, out_m[0]);
    chk({wr_tag(off), " R10 oe main"}, oe0, dir_m[0]);
    chk({wr_tag(off), " R11/R12 out alt"}, out1, out_m[1]);
    chk({wr_tag(off), " R11/R12 oe alt"}, oe1, dir_m[1]);
  endtask

  task automatic do_read(input int off);
    logic [W-1:0] e0, e1;
    e0 = exp_read(0, off);
    e1 = exp_read(1, off);
    addr = 3'(off); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk({rd_tag(off), " R10 rdata main"}, rdata0, e0);
    chk({rd_tag(off), " R11/R12 rdata alt"}, rdata1, e1);
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    gpio_in = v;
    repeat (3) @(negedge clk);
    pins_m = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [W-1:0] hold0, hold1;
    seed = $urandom(32'd20240611);
    for (int k = 0; k < 2; k++) begin out_m[k] = '0; dir_m[k] = '0; end

    repeat (4) @(negedge clk);
    // R1: state while reset is still asserted
    chk("R1 out during reset", out0, '0);
    chk("R1 oe during reset", oe0, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out main", out0, '0);
    chk("R1 oe alt", oe1, '0);
    do_read(3);
    do_read(4);

    // R11/R12: bus bit 0 lands on line 7 of the alternate instance
    do_write(1, 32'h0000_0001);
    chk("R11/R12 directed line 7", out1, 32'h0000_0080);
    chk("R3 directed line 0", out0, 32'h0000_0001);

    // R3/R4/R5/R6 directed
    do_write(0, 32'hA5A5_0F0F);
    do_write(1, 32'h0000_F000);
    do_write(2, 32'h0505_0001);
    do_read(1);
    do_read(2);

    // R7/R8: lockstep views of the direction word
    do_write(3, 32'hFFFF_0000);
    do_read(4);
    do_write(4, 32'h00FF_00FF);
    do_read(3);
    do_read(4);

    // R9: undefined offsets
    do_write(5, 32'hFFFF_FFFF);
    do_write(7, 32'h1234_5678);
    do_read(5);
    do_read(6);
    do_read(7);

    // R2: data register mixes latch and synchronised pins
    set_pins(32'h3C3C_C3C3);
    do_read(0);

    // R2: two-flop synchroniser depth, all lines inputs
    do_write(3, '0);
    set_pins(32'h1111_1111);
    gpio_in = 32'hEEEE_EEEE;
    addr = 3'd0; rd_en = 1'b1;
    @(negedge clk);
    chk("R2 sync first read old", rdata0, 32'h1111_1111);
    @(negedge clk);
    chk("R2 sync second read old", rdata0, 32'h1111_1111);
    @(negedge clk);
    chk("R2 sync third read new", rdata0, 32'hEEEE_EEEE);
    rd_en = 1'b0;
    pins_m = 32'hEEEE_EEEE;

    // R10: rdata holds without a read strobe
    do_read(0);
    hold0 = rdata0; hold1 = rdata1;
    gpio_in = 32'h0;
    do_write(3, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    pins_m = 32'h0;
    chk("R10 rdata hold main", rdata0, hold0);
    chk("R10 rdata hold alt", rdata1, hold1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 4;
      if (op < 2) do_write($urandom % 8, $urandom);
      else if (op == 2) do_read($urandom % 8);
      else set_pins($urandom);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule